// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames (start bit, data bits sent least significant first, optional parity bit, one stop bit). It samples the line on a 16x oversampling clock enable that an external baud divider supplies. Each completed byte moves from a receive shift register into a one-byte holding buffer, and a full flag reports that the buffer has something to read. A host reads the buffer with a single-cycle strobe.

Three sticky error indications report line problems: a bad stop bit, a parity mismatch and a lost byte. The lost-byte case happens when a new frame completes while the holding buffer is still unread. In that case the unread byte is kept, and only the shift register takes the new data. The host clears each error with a write-one-to-clear strobe. Dropping the receive enable returns the whole receiver to an empty, error-free idle state.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_full`, `fe_flag`, `pe_flag` and `oe_flag` are 0 and `rx_data` is 0x00.
- R2: With `rx_en` = 1, a low line seen on an `os_tick` and still low 8 ticks later is accepted as a start bit. Data bits are then sampled every 16 ticks, least significant bit first. At the stop bit the byte is stored in `rx_data` and `rx_full` goes to 1.
- R3: A low pulse shorter than half a bit period (fewer than 8 ticks) does not start a frame and stores no byte.
- R4: With `par_en` = 1, one parity bit follows the data bits. With `par_odd` = 1 the data bits plus the parity bit must hold an odd number of ones; with `par_odd` = 0 the number must be even. A mismatch sets `pe_flag` when the byte is transferred into the buffer. With `par_en` = 0 there is no parity bit and `pe_flag` never sets.
- R5: A frame whose stop bit is sampled as 0 sets `fe_flag`. The byte is still stored.
- R6: A frame that completes while `rx_full` = 1, with no read in the same cycle, sets `oe_flag`. `rx_data` keeps the unread byte and `rx_full` stays 1.
- R7: A `rd_strobe` pulse while `rx_full` = 1 clears `rx_full`.
- R8: A pulse on `err_wr` clears each flag whose bit in `err_wdata` is 1 (bit 0 framing, bit 1 parity, bit 2 overrun). A bit of 0 leaves that flag unchanged.
- R9: While `rx_en` = 0, all three error flags and `rx_full` are 0 and `rx_data` is 0x00 from the next clock on. The receiver stays idle and the line is ignored.
- R10: The receiver advances only on cycles where `os_tick` = 1. Any tick spacing gives the same received byte, and a low line with no ticks starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | 16x oversampling clock enable |
| rx_en | input | 1 | Receive enable; 0 clears and idles the receiver |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Host read of the holding buffer |
| err_wr | input | 1 | Error flag write strobe |
| err_wdata | input | 3 | Write-one-to-clear mask: bit 0 framing, bit 1 parity, bit 2 overrun |
| rx_data | output | 8 | Holding buffer contents |
| rx_full | output | 1 | Holding buffer holds an unread byte |
| fe_flag | output | 1 | Sticky framing error |
| pe_flag | output | 1 | Sticky parity error |
| oe_flag | output | 1 | Sticky overrun error |

## Verification
The bound checker watches the host-side rules on every cycle. It checks the clear-on-disable of flags and buffer, the read-clears-full rule, and that a flag is cleared by a one and held by a zero. It also checks that an overrun leaves the buffered byte untouched and that a parity error can only appear with parity enabled. Only the bench scenarios can show that the bits are put together in the right order and sampled at mid-bit. The same holds for telling even parity from odd, rejecting short start glitches, and giving the same byte at a different tick spacing, because these depend on the serial waveforms the bench builds.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

    localparam int NUM_ERR = 3;
    localparam int ERR_FE  = 0;
    localparam int ERR_PE  = 1;
    localparam int ERR_OE  = 2;

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 par_en,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 par_bit,
    output logic                 stop_bit
);
    localparam int CNT_W = $clog2(OVS);
    localparam int NB_W  = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [NB_W-1:0]  NB_LAST  = NB_W'(DATA_BITS - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        rx_state_e              st;
        logic [CNT_W-1:0]       cnt;
        logic [NB_W-1:0]        nbits;
        logic [DATA_BITS-1:0]   shreg;
        logic                   pbit;
        logic                   stop;
        logic                   done;
    } samp_t;

    samp_t q, d;
    logic  line;

    assign line = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[SYNC_STAGES-2:0], rxd};
        if (!en) begin
            d.st    = RX_IDLE;
            d.cnt   = '0;
            d.nbits = '0;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!line) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CNT_MID) begin
                        d.cnt = '0;
                        if (!line) begin
                            d.st    = RX_DATA;
                            d.nbits = '0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt   = '0;
                        d.shreg = {line, q.shreg[DATA_BITS-1:1]};
                        d.nbits = q.nbits + NB_W'(1);
                        if (q.nbits == NB_LAST) begin
                            d.st = par_en ? RX_PAR : RX_STOP;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                RX_PAR: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt  = '0;
                        d.pbit = line;
                        d.st   = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                RX_STOP: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt  = '0;
                        d.stop = line;
                        d.done = 1'b1;
                        d.st   = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync  <= '1;
            q.st    <= RX_IDLE;
            q.cnt   <= '0;
            q.nbits <= '0;
            q.shreg <= '0;
            q.pbit  <= 1'b0;
            q.stop  <= 1'b1;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign data     = q.shreg;
    assign par_bit  = q.pbit;
    assign stop_bit = q.stop;

endmodule

// File: rtl/rx_holding_buf.sv
module rx_holding_buf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] buf_data,
    output logic                 full,
    output logic                 load,
    output logic                 overrun
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
    } hold_t;

    hold_t q, d;

    always_comb begin
        load    = en && frame_done && (!q.full || rd);
        overrun = en && frame_done && q.full && !rd;
        d       = q;
        if (!en) begin
            d.data = '0;
            d.full = 1'b0;
        end else if (load) begin
            d.data = frame_data;
            d.full = 1'b1;
        end else if (rd) begin
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.data <= '0;
            q.full <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign buf_data = q.data;
    assign full     = q.full;

endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 frame_done,
    input  logic                 stop_bit,
    input  logic                 load,
    input  logic                 overrun,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 par_bit,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 wr,
    input  logic [NUM_ERR-1:0]   wdata,
    output logic [NUM_ERR-1:0]   flags
);
    typedef struct packed {
        logic [NUM_ERR-1:0] err;
    } flag_t;

    flag_t              q, d;
    logic [NUM_ERR-1:0] set_vec;
    logic [NUM_ERR-1:0] clr_vec;

    always_comb begin
        set_vec         = '0;
        set_vec[ERR_FE] = frame_done && !stop_bit;
        set_vec[ERR_PE] = load && par_en && ((^frame_data) ^ par_bit ^ par_odd);
        set_vec[ERR_OE] = overrun;
        clr_vec         = wr ? wdata : '0;
        d               = q;
        for (int i = 0; i < NUM_ERR; i++) begin
            if (!en) begin
                d.err[i] = 1'b0;
            end else begin
                d.err[i] = set_vec[i] | (q.err[i] & ~clr_vec[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.err <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags = q.err;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 os_tick,
    input  logic                 rx_en,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rd_strobe,
    input  logic                 err_wr,
    input  logic [NUM_ERR-1:0]   err_wdata,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 fe_flag,
    output logic                 pe_flag,
    output logic                 oe_flag
);
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_par;
    logic                 frm_stop;
    logic                 buf_load;
    logic                 buf_ovr;
    logic [NUM_ERR-1:0]   err_vec;

    rx_sampler #(
        .DATA_BITS  (DATA_BITS),
        .OVS        (OVS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .tick    (os_tick),
        .rxd     (rxd),
        .par_en  (par_en),
        .done    (frm_done),
        .data    (frm_data),
        .par_bit (frm_par),
        .stop_bit(frm_stop)
    );

    rx_holding_buf #(
        .DATA_BITS(DATA_BITS)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .frame_done(frm_done),
        .frame_data(frm_data),
        .rd        (rd_strobe),
        .buf_data  (rx_data),
        .full      (rx_full),
        .load      (buf_load),
        .overrun   (buf_ovr)
    );

    rx_err_flags #(
        .DATA_BITS(DATA_BITS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .frame_done(frm_done),
        .stop_bit  (frm_stop),
        .load      (buf_load),
        .overrun   (buf_ovr),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .par_bit   (frm_par),
        .frame_data(frm_data),
        .wr        (err_wr),
        .wdata     (err_wdata),
        .flags     (err_vec)
    );

    assign fe_flag = err_vec[ERR_FE];
    assign pe_flag = err_vec[ERR_PE];
    assign oe_flag = err_vec[ERR_OE];

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 par_en,
    input logic                 rd_strobe,
    input logic                 err_wr,
    input logic [2:0]           err_wdata,
    input logic                 frm_done,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 fe_flag,
    input logic                 pe_flag,
    input logic                 oe_flag
);
    // R9: disable empties the buffer and clears every flag
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_full && !fe_flag && !pe_flag && !oe_flag && rx_data == '0));

    // R6: an overrun keeps the unread byte
    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $rose(oe_flag)) |-> (rx_full && $stable(rx_data)));

    // R7: a read empties the buffer when no frame lands in the same cycle
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_full && rd_strobe && !frm_done) |=> !rx_full);

    // R8: a one clears the framing flag
    a_r8_w1c_fe: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && err_wr && err_wdata[0] && !frm_done) |=> !fe_flag);

    // R8: without a one in its bit the framing flag holds
    a_r8_hold_fe: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && fe_flag && !(err_wr && err_wdata[0])) |=> fe_flag);

    // R4: a parity error only appears with parity enabled
    a_r4_pe_needs_par: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !pe_flag) ##1 pe_flag |-> $past(par_en));
endmodule

bind serial_rx_core serial_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .par_en   (par_en),
    .rd_strobe(rd_strobe),
    .err_wr   (err_wr),
    .err_wdata(err_wdata),
    .frm_done (frm_done),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .fe_flag  (fe_flag),
    .pe_flag  (pe_flag),
    .oe_flag  (oe_flag)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       err_wr = 1'b0;
    logic [2:0] err_wdata = 3'b000;
    logic [7:0] rx_data;
    logic       rx_full, fe_flag, pe_flag, oe_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
        .rd_strobe(rd_strobe), .err_wr(err_wr), .err_wdata(err_wdata),
        .rx_data(rx_data), .rx_full(rx_full),
        .fe_flag(fe_flag), .pe_flag(pe_flag), .oe_flag(oe_flag)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick_once();
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        repeat (tick_div - 1) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16) tick_once();
    endtask

    task automatic send_frame(input logic [7:0] data, input bit with_par,
                              input logic pbit, input logic stopb);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(data[i]);
        if (with_par) drive_bit(pbit);
        drive_bit(stopb);
        rxd = 1'b1;
        repeat (24) tick_once();
    endtask

    task automatic read_buf();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_err(input logic [2:0] mask);
        err_wr = 1'b1;
        err_wdata = mask;
        @(negedge clk);
        err_wr = 1'b0;
        err_wdata = 3'b000;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 full", rx_full, 0);
        check("R1 data", rx_data, 8'h00);
        check("R1 flags", {fe_flag, pe_flag, oe_flag}, 3'b000);
    endtask

    task automatic t_basic();
        send_frame(8'h4B, 0, 1'b0, 1'b1);
        check("R2 full", rx_full, 1);
        check("R2 data lsb first", rx_data, 8'h4B);
        check("R4 no parity no pe", pe_flag, 0);
        read_buf();
        check("R7 read clears full", rx_full, 0);
        send_frame(8'h01, 0, 1'b0, 1'b1);
        check("R2 data 01", rx_data, 8'h01);
        read_buf();
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (4) tick_once();
        rxd = 1'b1;
        repeat (40) tick_once();
        check("R3 glitch ignored", rx_full, 0);
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        par_odd = 1'b0;
        send_frame(8'h4B, 1, 1'b0, 1'b1);
        check("R4 even ok data", rx_data, 8'h4B);
        check("R4 even ok pe", pe_flag, 0);
        read_buf();
        send_frame(8'h4B, 1, 1'b1, 1'b1);
        check("R4 even bad pe", pe_flag, 1);
        read_buf();
        write_err(3'b010);
        check("R8 clear pe", pe_flag, 0);
        par_odd = 1'b1;
        send_frame(8'h4B, 1, 1'b1, 1'b1);
        check("R4 odd ok pe", pe_flag, 0);
        read_buf();
        send_frame(8'h4B, 1, 1'b0, 1'b1);
        check("R4 odd bad pe", pe_flag, 1);
        read_buf();
        write_err(3'b010);
        par_en = 1'b0;
        par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 0, 1'b0, 1'b0);
        check("R5 fe set", fe_flag, 1);
        check("R5 byte stored", rx_data, 8'h81);
        write_err(3'b110);
        check("R8 zero bit keeps fe", fe_flag, 1);
        write_err(3'b001);
        check("R8 one clears fe", fe_flag, 0);
        read_buf();
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 0, 1'b0, 1'b1);
        send_frame(8'h22, 0, 1'b0, 1'b1);
        check("R6 oe set", oe_flag, 1);
        check("R6 old byte kept", rx_data, 8'h11);
        check("R6 still full", rx_full, 1);
        read_buf();
        send_frame(8'h33, 0, 1'b0, 1'b1);
        check("R6 accepts after read", rx_data, 8'h33);
        write_err(3'b100);
        check("R8 clear oe", oe_flag, 0);
        read_buf();
    endtask

    task automatic t_disable();
        send_frame(8'h5A, 0, 1'b0, 1'b0);
        send_frame(8'h5B, 0, 1'b0, 1'b1);
        check("R9 setup flags", {fe_flag, oe_flag, rx_full}, 3'b111);
        rx_en = 1'b0;
        @(negedge clk);
        check("R9 full cleared", rx_full, 0);
        check("R9 flags cleared", {fe_flag, pe_flag, oe_flag}, 3'b000);
        check("R9 data emptied", rx_data, 8'h00);
        send_frame(8'h55, 0, 1'b0, 1'b0);
        check("R9 line ignored", {rx_full, fe_flag}, 2'b00);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_tick();
        tick_div = 3;
        send_frame(8'h6D, 0, 1'b0, 1'b1);
        check("R10 slow ticks data", rx_data, 8'h6D);
        read_buf();
        tick_div = 1;
        rxd = 1'b0;
        repeat (60) @(negedge clk);
        rxd = 1'b1;
        repeat (40) tick_once();
        check("R10 no tick no start", rx_full, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        @(negedge clk);
        t_basic();
        t_glitch();
        t_parity();
        t_framing();
        t_overrun();
        t_disable();
        t_tick();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule